// File: doc/BRIEF.md
# Variable-Length Instruction Prefetch Queue

This block sits between a 64-bit instruction memory port and an instruction decoder that handles instructions from 1 to 8 bytes long. It requests aligned 8-byte words ahead of demand and unpacks them into a byte ring, so a memory that is slower than the decoder stays hidden behind the bytes already buffered. One fetch word can therefore hold several short instructions or only part of a long one.

The decoder sees a window of the next 8 bytes in stream order, together with the address of the first of them. Each cycle it may report how many bytes (1 to 8) the instruction at the head used, and those bytes leave the queue while a new word may arrive in the same cycle. A redirect, such as a taken branch, empties the queue, discards every word still on its way from memory, and restarts fetching at the aligned word that holds the target. Bytes of that first word that lie below the target are dropped.

The memory port uses a request/grant handshake with in-order responses. A request is not a commitment until it is granted, so the block may drop a request that was not granted.

Top module: `instr_prefetch_queue`

## Requirements
- R1: After reset the window is not valid and the first fetch request goes to the aligned word at the reset address (default 0).
- R2: Every fetch address is 8-byte aligned (bits 2:0 are zero). Granted fetches step by 8. The first fetch after a redirect targets the target address with bits 2:0 cleared.
- R3: A fetch is requested only while the free bytes in the queue are at least 8 more than 8 times the number of live outstanding fetches. With the decoder stalled after a redirect and a queue of 32 bytes, exactly 4 fetches are granted before fetching stops.
- R4: No more than MAX_OUT (default 4) fetches, live or discarded, are outstanding at any time.
- R5: Window byte i (bits 8i+7:8i of win_bytes) is the memory byte at win_pc + i, for i = 0 to 7.
- R6: The window is valid only when at least 8 bytes are buffered. A single word that supplies fewer than 8 bytes after a redirect does not make it valid.
- R7: A consume of win_len bytes (1 to 8) while the window is valid removes those bytes and advances win_pc by win_len at the next clock edge. A word arriving in the same cycle is still stored.
- R8: A redirect discards all buffered bytes and every fetch still in flight. From the next cycle, win_pc equals the target and the window is not valid. A consume in the same cycle as a redirect is ignored.
- R9: Bytes of the first word after a redirect that lie below the target offset are dropped, so the first window byte is the byte at the target address.
- R10: win_take has no effect while win_valid is low: win_pc and the byte stream are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | output | 1 | Fetch request to instruction memory |
| fetch_addr | output | ADDR_W | Aligned address of the requested word |
| fetch_gnt | input | 1 | Memory accepts the request in this cycle |
| fetch_rvalid | input | 1 | Response word valid, returned in request order |
| fetch_rdata | input | 64 | Response word; byte i at bits 8i+7:8i is address+i |
| redirect | input | 1 | Flush the queue and restart at redirect_addr |
| redirect_addr | input | ADDR_W | Byte address of the new stream head |
| win_valid | output | 1 | Window holds 8 buffered bytes |
| win_pc | output | ADDR_W | Address of window byte 0 |
| win_bytes | output | 64 | Next 8 stream bytes, byte 0 in bits 7:0 |
| win_take | input | 1 | Decoder consumes from the window |
| win_len | input | 4 | Bytes consumed, 1 to 8 |

## Verification
The assertions take for granted that memory never returns a response without an outstanding granted request, and that responses come back in request order. They also take for granted that the decoder reports a length of 1 to 8 whenever it consumes from a valid window. The bench memory model keeps an in-order queue of granted addresses and answers each entry after a random delay, and it keeps returning words that a redirect made stale. The decoder model draws lengths only from 1 to 8, and it sometimes asserts win_take while the window is not valid, to exercise R10 without breaking the length rule.

// File: rtl/pfq_pkg.sv
// Shared constants and types for the instruction prefetch queue.
// Assumes a fixed 64-bit fetch word split into eight byte lanes.
package pfq_pkg;
    localparam int BYTE_W     = 8;
    localparam int LANES      = 8;
    localparam int WORD_W     = BYTE_W * LANES;
    localparam int LANE_IDX_W = $clog2(LANES);
    localparam int LEN_W      = $clog2(LANES + 1);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [LEN_W-1:0]  len_t;
endpackage

// File: rtl/pfq_byte_ring.sv
// Circular byte store of the prefetch queue.
// Accepts one fetch word per cycle with a count of leading lanes to skip,
// removes 0..8 bytes per cycle from the head, and shows the 8 head bytes.
// Assumes QBYTES is a power of two, at least 2*LANES, and that the caller
// never pushes more bytes than are free. The data array has no reset;
// only the pointers and the count do.
module pfq_byte_ring
    import pfq_pkg::*;
#(
    parameter int QBYTES = 32,
    localparam int PTR_W = $clog2(QBYTES),
    localparam int CNT_W = $clog2(QBYTES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  push,
    input  logic [LANE_IDX_W-1:0] push_skip,
    input  logic [WORD_W-1:0]     push_word,
    input  logic                  pop,
    input  len_t                  pop_len,
    output logic [WORD_W-1:0]     rd_bytes,
    output logic [CNT_W-1:0]      occupancy
);
    byte_t             ring [QBYTES];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count;
    len_t              push_len;
    len_t              take_len;
    logic [PTR_W-1:0]  lane_dst [LANES];

    // Bytes added and removed this cycle.
    always_comb begin
        push_len = push ? (len_t'(LANES) - len_t'(push_skip)) : '0;
        take_len = pop ? pop_len : '0;
    end

    // Ring slot for each incoming lane, after removing skipped lanes.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane_dst[i] = wr_ptr + PTR_W'(i) - PTR_W'(push_skip);
        end
    end

    // Store the kept lanes of an arriving word.
    always_ff @(posedge clk) begin
        if (push) begin
            for (int i = 0; i < LANES; i++) begin
                if (i >= int'(push_skip)) begin
                    ring[lane_dst[i]] <= push_word[i*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    // Move the pointers and the fill count for push and pop together.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(push_len);
            rd_ptr <= rd_ptr + PTR_W'(take_len);
            count  <= count + CNT_W'(push_len) - CNT_W'(take_len);
        end
    end

    // Head window: eight bytes starting at the read pointer.
    for (genvar g = 0; g < LANES; g++) begin : g_window
        assign rd_bytes[g*BYTE_W +: BYTE_W] = ring[rd_ptr + PTR_W'(g)];
    end

    assign occupancy = count;
endmodule

// File: rtl/pfq_fetch_ctrl.sv
// Fetch issue and response bookkeeping of the prefetch queue.
// Issues aligned word requests while the queue has room for one more word
// beyond all live outstanding words. Counts outstanding requests, marks
// those in flight at a redirect as stale, and drops their responses. It also
// supplies the lane skip for the first live word after a redirect.
// Assumes in-order responses and no response without a granted request.
module pfq_fetch_ctrl
    import pfq_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                QBYTES     = 32,
    parameter int                MAX_OUT    = 4,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    localparam int CNT_W  = $clog2(QBYTES + 1),
    localparam int OUT_W  = $clog2(MAX_OUT + 1),
    localparam int CALC_W = CNT_W + OUT_W + LANE_IDX_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  redirect,
    input  logic [ADDR_W-1:0]     redirect_addr,
    input  logic [CNT_W-1:0]      occupancy,
    input  logic                  fetch_gnt,
    input  logic                  fetch_rvalid,
    output logic                  fetch_req,
    output logic [ADDR_W-1:0]     fetch_addr,
    output logic                  push,
    output logic [LANE_IDX_W-1:0] push_skip
);
    logic [ADDR_W-1:0]     next_addr;
    logic [OUT_W-1:0]      outst;
    logic [OUT_W-1:0]      stale;
    logic [OUT_W-1:0]      live;
    logic [LANE_IDX_W-1:0] skip_q;
    logic [CALC_W-1:0]     free_bytes;
    logic [CALC_W-1:0]     need_bytes;
    logic                  room_ok;
    logic                  grant;

    // Room check: free bytes must cover every live word plus one more.
    always_comb begin
        live       = outst - stale;
        free_bytes = CALC_W'(QBYTES) - CALC_W'(occupancy);
        need_bytes = (CALC_W'(live) + CALC_W'(1)) * CALC_W'(LANES);
        room_ok    = free_bytes >= need_bytes;
    end

    // Request, grant and push qualification.
    always_comb begin
        fetch_req  = !redirect && (outst < OUT_W'(MAX_OUT)) && room_ok;
        grant      = fetch_req && fetch_gnt;
        push       = fetch_rvalid && (stale == '0) && !redirect;
        fetch_addr = next_addr;
        push_skip  = skip_q;
    end

    // Track the fetch address, the outstanding and stale counts, and the skip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_addr <= {RESET_ADDR[ADDR_W-1:LANE_IDX_W], {LANE_IDX_W{1'b0}}};
            outst     <= '0;
            stale     <= '0;
            skip_q    <= RESET_ADDR[LANE_IDX_W-1:0];
        end else begin
            outst <= outst + OUT_W'(grant) - OUT_W'(fetch_rvalid);
            if (redirect) begin
                stale     <= outst - OUT_W'(fetch_rvalid);
                next_addr <= {redirect_addr[ADDR_W-1:LANE_IDX_W], {LANE_IDX_W{1'b0}}};
                skip_q    <= redirect_addr[LANE_IDX_W-1:0];
            end else begin
                if (fetch_rvalid && (stale != '0)) begin
                    stale <= stale - OUT_W'(1);
                end
                if (grant) begin
                    next_addr <= next_addr + ADDR_W'(LANES);
                end
                if (push) begin
                    skip_q <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/pfq_head_ptr.sv
// Address of the first byte in the decoder window.
// Loads the target on a redirect and steps by the consumed length otherwise.
// Assumes advance is only raised for a valid, non-redirect consume.
module pfq_head_ptr
    import pfq_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_addr,
    input  logic              advance,
    input  len_t              adv_len,
    output logic [ADDR_W-1:0] head_pc
);
    // Follow the stream head address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_pc <= RESET_ADDR;
        end else if (redirect) begin
            head_pc <= redirect_addr;
        end else if (advance) begin
            head_pc <= head_pc + ADDR_W'(adv_len);
        end
    end
endmodule

// File: rtl/instr_prefetch_queue.sv
// Instruction prefetch queue: packs aligned 64-bit fetch words into a byte
// stream and hands the decoder an 8-byte window with variable-length consume.
// Assumes an in-order memory port with a request/grant handshake and a
// decoder that consumes 1..8 bytes only while the window is valid.
module instr_prefetch_queue
    import pfq_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                QBYTES     = 32,
    parameter int                MAX_OUT    = 4,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    localparam int CNT_W = $clog2(QBYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_gnt,
    input  logic              fetch_rvalid,
    input  logic [WORD_W-1:0] fetch_rdata,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_addr,
    output logic              win_valid,
    output logic [ADDR_W-1:0] win_pc,
    output logic [WORD_W-1:0] win_bytes,
    input  logic              win_take,
    input  logic [LEN_W-1:0]  win_len
);
    logic [CNT_W-1:0]      occupancy;
    logic                  push;
    logic [LANE_IDX_W-1:0] push_skip;
    logic                  consume;

    // Window is ready once a full 8 bytes are buffered; redirect blocks consume.
    always_comb begin
        win_valid = occupancy >= CNT_W'(LANES);
        consume   = win_valid && win_take && !redirect;
    end

    pfq_fetch_ctrl #(
        .ADDR_W     (ADDR_W),
        .QBYTES     (QBYTES),
        .MAX_OUT    (MAX_OUT),
        .RESET_ADDR (RESET_ADDR)
    ) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .redirect      (redirect),
        .redirect_addr (redirect_addr),
        .occupancy     (occupancy),
        .fetch_gnt     (fetch_gnt),
        .fetch_rvalid  (fetch_rvalid),
        .fetch_req     (fetch_req),
        .fetch_addr    (fetch_addr),
        .push          (push),
        .push_skip     (push_skip)
    );

    pfq_byte_ring #(
        .QBYTES (QBYTES)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (redirect),
        .push      (push),
        .push_skip (push_skip),
        .push_word (fetch_rdata),
        .pop       (consume),
        .pop_len   (win_len),
        .rd_bytes  (win_bytes),
        .occupancy (occupancy)
    );

    pfq_head_ptr #(
        .ADDR_W     (ADDR_W),
        .RESET_ADDR (RESET_ADDR)
    ) u_head (
        .clk           (clk),
        .rst_n         (rst_n),
        .redirect      (redirect),
        .redirect_addr (redirect_addr),
        .advance       (consume),
        .adv_len       (win_len),
        .head_pc       (win_pc)
    );
endmodule

// File: rtl/pfq_checker.sv
// Property checker for the instruction prefetch queue, bound to the top.
// Keeps its own count of outstanding fetches from the port handshake.
module pfq_checker
    import pfq_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int QBYTES  = 32,
    parameter int MAX_OUT = 4,
    localparam int CNT_W  = $clog2(QBYTES + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  fetch_req,
    input logic [LANE_IDX_W-1:0] fetch_lo,
    input logic                  fetch_gnt,
    input logic                  fetch_rvalid,
    input logic                  redirect,
    input logic [ADDR_W-1:0]     redirect_addr,
    input logic                  win_valid,
    input logic [ADDR_W-1:0]     win_pc,
    input logic                  win_take,
    input logic [LEN_W-1:0]      win_len,
    input logic [CNT_W-1:0]      occupancy
);
    logic [7:0] seen_out;

    // Outstanding fetches as seen at the memory port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_out <= '0;
        end else begin
            seen_out <= seen_out + 8'(fetch_req && fetch_gnt) - 8'(fetch_rvalid);
        end
    end

    a_r4_max_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        seen_out <= 8'(MAX_OUT));

    a_r4_resp_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rvalid |-> (seen_out != '0));

    a_r2_aligned_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (fetch_lo == '0));

    a_r8_no_fetch_on_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> !fetch_req);

    a_r8_redirect_head: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (win_pc == $past(redirect_addr)) && !win_valid);

    a_r7_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && win_take) |-> (win_len >= LEN_W'(1)) && (win_len <= LEN_W'(LANES)));

    a_r7_head_step: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && win_take && !redirect) |=> (win_pc == $past(win_pc) + ADDR_W'($past(win_len))));

    a_r10_hold_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_valid && !redirect) |=> (win_pc == $past(win_pc)));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(QBYTES));
endmodule

bind instr_prefetch_queue pfq_checker #(
    .ADDR_W  (ADDR_W),
    .QBYTES  (QBYTES),
    .MAX_OUT (MAX_OUT)
) u_pfq_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_req     (fetch_req),
    .fetch_lo      (fetch_addr[2:0]),
    .fetch_gnt     (fetch_gnt),
    .fetch_rvalid  (fetch_rvalid),
    .redirect      (redirect),
    .redirect_addr (redirect_addr),
    .win_valid     (win_valid),
    .win_pc        (win_pc),
    .win_take      (win_take),
    .win_len       (win_len),
    .occupancy     (occupancy)
);

// File: tb/instr_prefetch_queue_bench.sv
module instr_prefetch_queue_bench;
    localparam int ADDR_W  = 32;
    localparam int QBYTES  = 32;
    localparam int MAX_OUT = 4;

    logic              clk;
    logic              rst_n;
    logic              fetch_req;
    logic [ADDR_W-1:0] fetch_addr;
    logic              fetch_gnt;
    logic              fetch_rvalid;
    logic [63:0]       fetch_rdata;
    logic              redirect;
    logic [ADDR_W-1:0] redirect_addr;
    logic              win_valid;
    logic [ADDR_W-1:0] win_pc;
    logic [63:0]       win_bytes;
    logic              win_take;
    logic [3:0]        win_len;

    instr_prefetch_queue #(
        .ADDR_W     (ADDR_W),
        .QBYTES     (QBYTES),
        .MAX_OUT    (MAX_OUT),
        .RESET_ADDR ('0)
    ) u_instr_prefetch_queue (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_req     (fetch_req),
        .fetch_addr    (fetch_addr),
        .fetch_gnt     (fetch_gnt),
        .fetch_rvalid  (fetch_rvalid),
        .fetch_rdata   (fetch_rdata),
        .redirect      (redirect),
        .redirect_addr (redirect_addr),
        .win_valid     (win_valid),
        .win_pc        (win_pc),
        .win_bytes     (win_bytes),
        .win_take      (win_take),
        .win_len       (win_len)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;

    // Bench model state.
    logic [31:0] exp_pc;
    logic [31:0] exp_fetch;
    logic [31:0] mq_addr [16];
    int          mq_due  [16];
    int          mq_head = 0;
    int          mq_tail = 0;
    int          mq_n    = 0;
    int          gnt_mode = 0;   // 0 random, 1 always, 2 limited budget
    int          budget = 0;
    int          grants_seen = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [63:0] mem_word(input logic [31:0] a);
        logic [63:0] w;
        for (int i = 0; i < 8; i++) w[i*8 +: 8] = mem_byte(a + 32'(i));
        return w;
    endfunction

    // One clock of stimulus, model update and memory response.
    task automatic step(input bit do_redir, input logic [31:0] tgt, input bit want_take, input logic [3:0] len);
        bit g;
        @(negedge clk);
        if (win_valid) begin
            check(win_pc == exp_pc, "R5 R7 head address", 64'(win_pc), 64'(exp_pc));
            check(win_bytes == mem_word(exp_pc), "R5 R9 window bytes", win_bytes, mem_word(exp_pc));
        end
        redirect      = do_redir;
        redirect_addr = tgt;
        win_take      = want_take;
        win_len       = len;
        if (do_redir) begin
            exp_pc    = tgt;                       // R8: redirect outranks consume
            exp_fetch = {tgt[31:3], 3'b000};
        end else if (win_valid && want_take) begin
            exp_pc = exp_pc + 32'(len);            // R10: no step when not valid
        end
        #1;
        case (gnt_mode)
            0: g = ($urandom_range(0, 99) < 70);
            1: g = 1'b1;
            default: g = (budget > 0);
        endcase
        fetch_gnt = g;
        if (fetch_req && g) begin
            check(fetch_addr == exp_fetch, "R2 fetch address", 64'(fetch_addr), 64'(exp_fetch));
            mq_addr[mq_tail] = fetch_addr;
            mq_due[mq_tail]  = cyc + 1 + int'($urandom_range(0, 4));
            mq_tail = (mq_tail + 1) % 16;
            mq_n++;
            check(mq_n <= MAX_OUT, "R4 outstanding fetches", 64'(mq_n), 64'(MAX_OUT));
            exp_fetch = exp_fetch + 32'd8;
            grants_seen++;
            if (gnt_mode == 2) budget--;
        end
        if (mq_n > 0 && mq_due[mq_head] <= cyc) begin
            fetch_rvalid = 1'b1;
            fetch_rdata  = mem_word(mq_addr[mq_head]);
            mq_head = (mq_head + 1) % 16;
            mq_n--;
        end else begin
            fetch_rvalid = 1'b0;
            fetch_rdata  = '0;
        end
    endtask

    initial begin
        int unsigned seed_set;
        bit any_v;
        seed_set = $urandom(32'h1F2E3D4C);
        rst_n = 1'b0; fetch_gnt = 1'b0; fetch_rvalid = 1'b0; fetch_rdata = '0;
        redirect = 1'b0; redirect_addr = '0; win_take = 1'b0; win_len = 4'd1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(win_valid == 1'b0, "R1 window invalid after reset", 64'(win_valid), 64'd0);
        check(fetch_req == 1'b1, "R1 fetch requested after reset", 64'(fetch_req), 64'd1);
        check(fetch_addr == 32'd0, "R1 first fetch address", 64'(fetch_addr), 64'd0);
        exp_pc = 32'd0;
        exp_fetch = 32'd0;

        // R3: decoder stalled, queue fills with exactly four words
        step(1'b1, 32'h200, 1'b0, 4'd1);
        gnt_mode = 1; grants_seen = 0;
        repeat (60) step(1'b0, 32'h0, 1'b0, 4'd1);
        check(grants_seen == 4, "R3 words fetched with stalled decoder, aligned", 64'(grants_seen), 64'd4);
        check(win_valid == 1'b1, "R3 window valid when full", 64'(win_valid), 64'd1);

        step(1'b1, 32'h305, 1'b0, 4'd1);
        grants_seen = 0;
        repeat (60) step(1'b0, 32'h0, 1'b0, 4'd1);
        check(grants_seen == 4, "R3 words fetched with stalled decoder, offset 5", 64'(grants_seen), 64'd4);
        check(win_pc == 32'h305, "R9 head after offset redirect", 64'(win_pc), 64'h305);

        // R8: redirect with a same-cycle consume on a full window
        step(1'b1, 32'h480, 1'b1, 4'd8);
        repeat (30) step(1'b0, 32'h0, 1'b0, 4'd1);
        check(win_valid && win_pc == 32'h480, "R8 head after redirect with consume", 64'(win_pc), 64'h480);

        // R6: one word with a single kept byte does not open the window
        gnt_mode = 2; budget = 1;
        step(1'b1, 32'h107, 1'b0, 4'd1);
        any_v = 1'b0;
        repeat (20) begin
            step(1'b0, 32'h0, 1'b1, 4'd1);       // R10: take while not valid
            any_v |= win_valid;
        end
        check(any_v == 1'b0, "R6 window stays invalid with 1 byte", 64'(any_v), 64'd0);
        budget = 1;
        repeat (20) step(1'b0, 32'h0, 1'b0, 4'd1);
        check(win_valid == 1'b1, "R6 window valid with 9 bytes", 64'(win_valid), 64'd1);
        check(win_pc == 32'h107, "R10 head unchanged by take while invalid", 64'(win_pc), 64'h107);

        // Random mix of consumes, redirects and memory delays (R5 R7 R8 R9 R10)
        gnt_mode = 0;
        for (int k = 0; k < 4000; k++) begin
            bit rd;
            bit tk;
            rd = ($urandom_range(0, 99) < 3);
            tk = ($urandom_range(0, 99) < 70);
            step(rd, 32'($urandom_range(0, 16'hFFFF)), tk, 4'(1 + $urandom_range(0, 7)));
        end
        repeat (10) step(1'b0, 32'h0, 1'b0, 4'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule